// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a 16-bit, four-bank SDRAM from reset onward. It first takes the memory through its start-up sequence. Clock enable and the data masks stay high, and NOP commands are driven for the whole power-up delay. The block then closes every bank with one precharge and issues a fixed number of auto-refresh commands at row-cycle spacing. Last, it programs the mode register and raises a ready flag once the mode-set recovery has passed.

After start-up, a timer counts the refresh interval, which is derived from the clock period. Each expiry adds one to a small count of refreshes owed. While that count is non-zero, the block raises a request to the user-side arbiter. The arbiter closes all banks and answers with a grant. The block then issues one auto-refresh and keeps the request high until the row-cycle time after it has passed. Expiries that arrive while the grant is withheld are remembered up to a limit. Each one is then served by its own refresh.

Top module: `sdram_init_refresh`

## Requirements
- R1: From reset until the start-up delay has passed, the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), dqm=2'b11, ready=0 and ref_req=0. The delay is at least T_POWERUP_NS rounded up to whole clock periods.
- R2: The first command after the delay is precharge-all: cs_n/ras_n/cas_n/we_n = 0/0/1/0 with addr[10]=1.
- R3: After the precharge come exactly INIT_REFRESHES auto-refresh commands (pins 0/0/0/1). The first is at least the precharge time after the precharge, and each later one is at least the row-cycle time after the previous one.
- R4: At least the row-cycle time after the last start-up refresh, a mode-register set (pins 0/0/0/0) is issued with ba=0 and addr[11:7]=0. The word carries addr[6:4] = CAS latency code, addr[3] = burst type and addr[2:0] = burst length code.
- R5: ready rises at least T_RSC_CYC cycles after the mode-register set and never falls again. dqm is 2'b11 while ready is low and 2'b00 while it is high.
- R6: cs_n is low and cke is high in every cycle after reset. Every cycle without a command carries the NOP pattern.
- R7: ref_req first rises exactly REFI cycles after the cycle in which ready first reads high. REFI is T_REFI_NS divided by the clock period, rounded down. Further expiries follow every REFI cycles.
- R8: In normal operation, an auto-refresh is issued only in the cycle after ref_gnt was sampled high while a refresh was owed. A withheld grant causes no refresh. ref_req stays high for the refresh cycle and the following row-cycle time, then falls if nothing more is owed.
- R9: Expiries that occur while the grant is withheld are each served by a separate auto-refresh, back to back at row-cycle spacing. An expiry in the same cycle in which a grant is taken is not lost.
- R10: The count of owed refreshes saturates at DEBT_MAX. After more than DEBT_MAX withheld expiries, exactly DEBT_MAX refreshes follow a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant: all banks idle, a refresh may be issued |
| ready | output | 1 | Start-up sequence complete |
| ref_req | output | 1 | Refresh owed or in progress |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus (mode word, precharge-all bit) |
| dqm | output | 2 | Data mask, upper and lower byte |

## Verification
The interval timer expiry and the taking of a grant can fall in the same cycle. In that cycle the owed count must go up and down at once and keep its value. The bench provokes this by first withholding the grant across one expiry, so one refresh is owed. It then raises the grant exactly one cycle before the next expiry, counting cycles from the first ready cycle. The result is judged at the pins: the first refresh must appear in the expiry cycle, and a second one must follow at row-cycle spacing before ref_req falls. A lost increment or decrement changes that count.

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh #(
  parameter int CLK_PERIOD_PS  = 10000,
  parameter int T_POWERUP_NS   = 200000,
  parameter int T_RP_NS        = 20,
  parameter int T_RC_NS        = 70,
  parameter int T_RSC_CYC      = 2,
  parameter int INIT_REFRESHES = 8,
  parameter int T_REFI_NS      = 15625,
  parameter int DEBT_MAX       = 8,
  parameter int ADDR_W         = 12,
  parameter logic [2:0] BURST_LEN_CODE = 3'd3,
  parameter logic       BURST_TYPE     = 1'b0,
  parameter logic [2:0] CAS_LAT_CODE   = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              ready,
  output logic              ref_req,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        dqm
);
  function automatic int ceil_cyc(int ns);
    return (ns * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  endfunction
  function automatic int at_least2(int v);
    return (v < 2) ? 2 : v;
  endfunction

  localparam int PWR_CYC  = (ceil_cyc(T_POWERUP_NS) < 1) ? 1 : ceil_cyc(T_POWERUP_NS);
  localparam int RP_CYC   = at_least2(ceil_cyc(T_RP_NS));
  localparam int RC_CYC   = at_least2(ceil_cyc(T_RC_NS));
  localparam int RSC_CYC  = at_least2(T_RSC_CYC);
  localparam int REFI_CYC = (T_REFI_NS * 1000) / CLK_PERIOD_PS;
  localparam int CW = $clog2(PWR_CYC + RP_CYC + RC_CYC + RSC_CYC + 1);
  localparam int TW = $clog2(REFI_CYC + 1);
  localparam int RW = $clog2(INIT_REFRESHES + 1);
  localparam int DW = $clog2(DEBT_MAX + 1);

  typedef enum logic [3:0] {
    S_PWR, S_PREA, S_WRP, S_REF, S_WRC, S_MRS, S_WRSC, S_RUN, S_AREF, S_ARC
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  nref;
  logic [TW-1:0]  tmr;
  logic [DW-1:0]  debt;
  logic           take, expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_PWR;
      cnt  <= CW'(PWR_CYC - 1);
      nref <= '0;
    end else begin
      case (st)
        S_PWR:  if (cnt == 0) st <= S_PREA; else cnt <= cnt - 1'b1;
        S_PREA: begin cnt <= CW'(RP_CYC - 2); st <= S_WRP; end
        S_WRP:  if (cnt == 0) st <= S_REF; else cnt <= cnt - 1'b1;
        S_REF:  begin cnt <= CW'(RC_CYC - 2); st <= S_WRC; end
        S_WRC:
          if (cnt != 0) cnt <= cnt - 1'b1;
          else if (nref == RW'(INIT_REFRESHES - 1)) st <= S_MRS;
          else begin
            nref <= nref + 1'b1;
            st   <= S_REF;
          end
        S_MRS:  begin cnt <= CW'(RSC_CYC - 2); st <= S_WRSC; end
        S_WRSC: if (cnt == 0) st <= S_RUN; else cnt <= cnt - 1'b1;
        S_RUN:  if (take) st <= S_AREF;
        S_AREF: begin cnt <= CW'(RC_CYC - 2); st <= S_ARC; end
        S_ARC:  if (cnt == 0) st <= S_RUN; else cnt <= cnt - 1'b1;
        default: st <= S_PWR;
      endcase
    end
  end

  assign ready  = (st == S_RUN) || (st == S_AREF) || (st == S_ARC);
  assign take   = (st == S_RUN) && (debt != 0) && ref_gnt;
  assign expire = ready && (tmr == 0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr  <= '0;
      debt <= '0;
    end else begin
      if (st == S_WRSC && cnt == 0) tmr <= TW'(REFI_CYC - 1);
      else if (ready)               tmr <= (tmr == 0) ? TW'(REFI_CYC - 1) : tmr - 1'b1;
      case ({expire, take})
        2'b10:   if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  logic is_prea, is_ref, is_mrs;
  assign is_prea = (st == S_PREA);
  assign is_ref  = (st == S_REF) || (st == S_AREF);
  assign is_mrs  = (st == S_MRS);

  assign ref_req = (debt != 0) || (st == S_AREF) || (st == S_ARC);
  assign cke     = 1'b1;
  assign cs_n    = 1'b0;
  assign ras_n   = !(is_prea || is_ref || is_mrs);
  assign cas_n   = !(is_ref || is_mrs);
  assign we_n    = !(is_prea || is_mrs);
  assign ba      = 2'b00;
  assign dqm     = ready ? 2'b00 : 2'b11;

  always_comb begin
    addr = '0;
    if (is_mrs)  addr[6:0] = {CAS_LAT_CODE, BURST_TYPE, BURST_LEN_CODE};
    if (is_prea) addr[10]  = 1'b1;
  end
endmodule

// File: rtl/sdram_init_refresh_chk.sv
module sdram_init_refresh_chk #(
  parameter int RC_CYC = 7,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_gnt,
  input logic              ready,
  input logic              ref_req,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        dqm
);
  localparam int GW = $clog2(RC_CYC + 2);

  logic is_prea, is_refa, is_mrs;
  assign is_prea = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_refa = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_mrs  = !cs_n && !ras_n && !cas_n && !we_n;

  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                   gap <= GW'(RC_CYC);
    else if (is_refa)             gap <= GW'(1);
    else if (gap != GW'(RC_CYC))  gap <= gap + 1'b1;
  end

  a_r6_pins_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    cke && !cs_n);
  a_r2_prea_all_bit: assert property (@(posedge clk) disable iff (!rst_n)
    is_prea |-> addr[10]);
  a_r4_mrs_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (!ready && ba == 2'b00));
  a_r5_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r5_dqm_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ready ? (dqm == 2'b00) : (dqm == 2'b11));
  a_r3_refa_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_refa |-> (gap >= GW'(RC_CYC)));
  a_r8_refa_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && is_refa) |-> ($past(ref_gnt) && ref_req));
endmodule

bind sdram_init_refresh sdram_init_refresh_chk #(.RC_CYC(RC_CYC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ready(ready), .ref_req(ref_req),
  .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .addr(addr), .dqm(dqm)
);

// File: tb/sdram_init_refresh_test.sv
module sdram_init_refresh_test;
  localparam int CLK_PERIOD = 10;
  localparam int PWR  = 200;
  localparam int RP   = 2;
  localparam int RC   = 7;
  localparam int RSC  = 2;
  localparam int NINIT = 8;
  localparam int REFI = 300;
  localparam int DMAX = 3;
  localparam logic [11:0] MODE_WORD = {5'b0, 3'b010, 1'b1, 3'b010};

  localparam int K_PREA = 1, K_REFA = 2, K_MRS = 3, K_BAD = 9;

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ready, ref_req, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba, dqm;
  logic [11:0] addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_refresh #(
    .CLK_PERIOD_PS(10000), .T_POWERUP_NS(2000), .T_RP_NS(20), .T_RC_NS(70),
    .T_RSC_CYC(2), .INIT_REFRESHES(8), .T_REFI_NS(3000), .DEBT_MAX(3), .ADDR_W(12),
    .BURST_LEN_CODE(3'd2), .BURST_TYPE(1'b1), .CAS_LAT_CODE(3'd2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ready(ready), .ref_req(ref_req),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .dqm(dqm)
  );

  typedef struct { int kind; int min_gap; int at_cyc; } exp_t;
  exp_t q[$];

  int nchk = 0, nfail = 0;
  int cyc = 0, last_cmd = 0, last_refa = -1, mrs_cyc = -1, rdy_cyc = -1;
  bit pins_bad = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic expect_cmd(int kind, int min_gap, int at_cyc);
    exp_t e;
    e.kind = kind; e.min_gap = min_gap; e.at_cyc = at_cyc;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) step();
  endtask

  // monitor: pops the scoreboard on every non-NOP command
  always @(negedge clk) begin
    if (rst_n) begin
      int kind;
      exp_t e;
      cyc++;
      if (cke !== 1'b1 || cs_n !== 1'b0) pins_bad = 1;
      case ({ras_n, cas_n, we_n})
        3'b111: kind = 0;
        3'b010: kind = K_PREA;
        3'b001: kind = K_REFA;
        3'b000: kind = K_MRS;
        default: kind = K_BAD;
      endcase
      if (kind != 0) begin
        if (q.size() == 0) begin
          chk(0, "R8", "unexpected command kind", kind, 0);
        end else begin
          e = q.pop_front();
          chk(kind == e.kind, "R3", "command kind in order", kind, e.kind);
          chk(cyc - last_cmd >= e.min_gap, "R3", "spacing to previous command", cyc - last_cmd, e.min_gap);
          if (e.at_cyc >= 0)
            chk(cyc == e.at_cyc, "R9", "refresh issue cycle", cyc, e.at_cyc);
          if (kind == K_PREA)
            chk(addr[10] == 1'b1, "R2", "precharge-all bit", addr[10], 1);
          if (kind == K_MRS) begin
            chk(addr == MODE_WORD && ba == 2'b00, "R4", "mode word", addr, MODE_WORD);
            mrs_cyc = cyc;
          end
        end
        last_cmd = cyc;
        if (kind == K_REFA) last_refa = cyc;
      end
      if (ready === 1'b1 && rdy_cyc < 0) rdy_cyc = cyc;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1", "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    expect_cmd(K_PREA, PWR, -1);
    expect_cmd(K_REFA, RP, -1);
    for (int i = 1; i < NINIT; i++) expect_cmd(K_REFA, RC, -1);
    expect_cmd(K_MRS, RC, -1);

    repeat (3) @(negedge clk);
    #1;
    chk(ready == 0 && ref_req == 0, "R1", "ready/ref_req in reset", {ready, ref_req}, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "NOP in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(dqm == 2'b11, "R1", "dqm in reset", dqm, 3);
    rst_n = 1;

    wait_until(PWR - 1);
    chk(ready == 0 && ref_req == 0 && dqm == 2'b11, "R1", "quiet during start-up delay", {ready, ref_req, dqm}, 3);

    while (rdy_cyc < 0) step();
    chk(q.size() == 0, "R3", "start-up commands left", q.size(), 0);
    chk(rdy_cyc - mrs_cyc >= RSC, "R5", "mode-set to ready", rdy_cyc - mrs_cyc, RSC);
    chk(dqm == 2'b00, "R5", "dqm after ready", dqm, 0);

    // R7: first request after one interval
    while (!ref_req) step();
    chk(cyc - rdy_cyc == REFI, "R7", "first request delay", cyc - rdy_cyc, REFI);

    // R8: withheld grant causes no refresh
    repeat (50) step();
    chk(ref_req == 1 && last_refa < rdy_cyc, "R8", "no refresh without grant", last_refa, -1);

    expect_cmd(K_REFA, 0, cyc + 1);
    ref_gnt = 1;
    step();
    while (ref_req) step();
    chk(cyc - last_refa == RC, "R8", "request held through row cycle", cyc - last_refa, RC);
    ref_gnt = 0;
    chk(ready == 1, "R5", "ready stays high", ready, 1);

    // R9: two withheld expiries served by two refreshes
    wait_until(rdy_cyc + 3 * REFI + 5);
    expect_cmd(K_REFA, 0, cyc + 1);
    expect_cmd(K_REFA, RC, -1);
    ref_gnt = 1;
    step();
    while (ref_req) step();
    ref_gnt = 0;
    chk(q.size() == 0, "R9", "postponed refreshes pending", q.size(), 0);

    // R9: grant taken in the expiry cycle with one refresh owed
    wait_until(rdy_cyc + 5 * REFI - 1);
    chk(ref_req == 1, "R9", "one refresh owed before coincidence", ref_req, 1);
    expect_cmd(K_REFA, 0, cyc + 1);
    expect_cmd(K_REFA, RC, -1);
    ref_gnt = 1;
    step();
    while (ref_req) step();
    ref_gnt = 0;
    chk(q.size() == 0, "R9", "refreshes after coincident expiry", q.size(), 0);

    // R10: five withheld expiries saturate at DMAX
    wait_until(rdy_cyc + 10 * REFI + 5);
    expect_cmd(K_REFA, 0, cyc + 1);
    for (int i = 1; i < DMAX; i++) expect_cmd(K_REFA, RC, -1);
    ref_gnt = 1;
    step();
    while (ref_req) step();
    ref_gnt = 0;
    chk(q.size() == 0, "R10", "saturated refresh count", q.size(), 0);
    repeat (40) step();
    chk(ref_req == 0, "R10", "no extra request after saturation", ref_req, 0);

    chk(!pins_bad, "R6", "cs_n low and cke high every cycle", pins_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule